// File: doc/BRIEF.md
# Receive Word FIFO with Programmable Level Flags

This block buffers 32-bit words arriving from a parallel cable input before a DMA engine or host drains them through one fixed data address. Words from the cable side are taken only while the receive enable is on. A small register interface sets the two level thresholds, reads a status word, reads the current fill count and the configured size, and holds the enable and flush controls.

The status word gives four level flags and two sticky error flags. The level flags use inverted polarity: each bit is 1 while its condition is false. A push into a full buffer drops the word and sets the overrun flag. A pop from an empty buffer returns the last word delivered and sets the underrun flag. Both error flags stay set until software writes 1 to their bit position. A flush empties the buffer and leaves the error flags as they are.

Register reads are registered. `bus_rdata` shows the addressed value on the clock edge that accepts `bus_rd`. The value is taken before that access changes any state. Register writes take effect at the edge that accepts them.

Top module: `rx_port_fifo`

## Requirements
- R1: After reset the buffer is empty and the receive enable is off. The status word reads 0x0000C000: not-full (bit 15) and not-almost-full (bit 14) are set, and everything else is clear. This holds with thresholds of zero.
- R2: Reading address 3 (data) pops the oldest word. Words come out in the order they were accepted.
- R3: A cable word (`rx_valid`) is ignored while the enable bit (bit 1 of the control register at address 0) is clear. The fill count does not change.
- R4: Thresholds register at address 1 holds the almost-empty level in bits 15:0. Status bit 13 (not-almost-empty) is 0 while the fill count is less than or equal to that level.
- R5: The almost-full level is in bits 23:16 of address 1. Status bit 14 (not-almost-full) is 0 while fill count + level >= DEPTH.
- R6: Status bit 12 (not-empty) is 1 while the fill count is above zero. Status bit 15 (not-full) is 1 while the fill count is below DEPTH.
- R7: A cable word arriving while the buffer is full, with no pop in the same cycle, is dropped. It sets sticky overrun at status bit 23.
- R8: A data read while the buffer is empty returns the last word popped. It sets sticky underrun at status bit 22.
- R9: Writing the status register with 1 in bit 22 or bit 23 clears that flag. A 0 in that position leaves it unchanged. A new error in the same cycle as its clear wins, and the flag stays set.
- R10: Writing 1 to control bit 0 flushes the buffer to a count of zero. The flush does not clear the error flags, and it drops a cable word arriving in the same cycle.
- R11: Address 4 returns the fill count and address 5 returns DEPTH. Each value is in bits 19:0 with the upper bits zero.
- R12: A cable word and a data read in the same cycle on a full buffer both succeed. The count stays at DEPTH and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Cable word strobe |
| rx_word | input | 32 | Cable word |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address (0 control, 1 thresholds, 2 status, 3 data, 4 fill, 5 size) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
A cable push and a data-address pop can land in the same cycle. On a full buffer, the bench drives `rx_valid` and a data read on the same clock edge. It then checks three things: the read returned the oldest word, the fill count stayed at DEPTH, and overrun stayed clear. It then drains the buffer and expects the pushed word to come out last. The same approach covers two other collisions: an overrun that coincides with its write-1 clear, which must leave the flag set, and a flush that coincides with a cable word, which must leave the count at zero.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_LEVELS = 3'd1,
    A_STATUS = 3'd2,
    A_DATA   = 3'd3,
    A_FILL   = 3'd4,
    A_SIZE   = 3'd5
  } reg_addr_e;

  localparam int unsigned CTRL_FLUSH  = 0;
  localparam int unsigned CTRL_EN     = 1;
  localparam int unsigned ST_NEMPTY   = 12;
  localparam int unsigned ST_NAEMPTY  = 13;
  localparam int unsigned ST_NAFULL   = 14;
  localparam int unsigned ST_NFULL    = 15;
  localparam int unsigned ST_UNDER    = 22;
  localparam int unsigned ST_OVER     = 23;
  localparam int unsigned AE_LSB      = 0;
  localparam int unsigned AE_W        = 16;
  localparam int unsigned AF_LSB      = 16;
  localparam int unsigned AF_W        = 8;
  localparam int unsigned LVL_W       = AF_LSB + AF_W;
  localparam int unsigned CNT_FIELD_W = 20;
  localparam int unsigned ERR_UNDER   = 0;
  localparam int unsigned ERR_OVER    = 1;
  localparam int unsigned ERR_N       = 2;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic                         pop,
  input  logic [DW-1:0]                wdata,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (pop)  rd_ptr_d = ptr_inc(rd_ptr_q);
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= wdata;
  end

  assign head  = mem[rd_ptr_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));
  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !flush) |=> full);
  // R8
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/rxf_levels.sv
module rxf_levels #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5,
  parameter int unsigned AEW   = 16,
  parameter int unsigned AFW   = 8
) (
  input  logic [CW-1:0]  count,
  input  logic [AEW-1:0] ae_level,
  input  logic [AFW-1:0] af_level,
  output logic           almost_empty,
  output logic           almost_full
);
  localparam int unsigned XW = 34;

  logic [XW-1:0] cnt_x, ae_x, af_x;

  always_comb begin
    cnt_x        = XW'(count);
    ae_x         = XW'(ae_level);
    af_x         = XW'(af_level);
    almost_empty = (cnt_x <= ae_x);
    almost_full  = ((cnt_x + af_x) >= XW'(DEPTH));
  end
endmodule

// File: rtl/rxf_sticky.sv
module rxf_sticky #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] flag_q, flag_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb flag_d[i] = set[i] | (flag_q[i] & ~clr[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !clr[i]) |=> flag_q[i]);
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flag_q[i]);
  end

  assign flags = flag_q;
endmodule

// File: rtl/rx_port_fifo.sv
module rx_port_fifo #(
  parameter int unsigned DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [31:0] rx_word,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  import rxf_pkg::*;

  localparam int unsigned DW = 32;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic              en_q, en_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [DW-1:0]     rdata_q, rdata_d;
  logic [DW-1:0]     last_q, last_d;

  logic              wr_ctrl, wr_lvl, wr_stat, rd_dat;
  logic              flush, push, pop;
  logic [DW-1:0]     head;
  logic [CW-1:0]     fill;
  logic              full, empty, aempty, afull;
  logic [ERR_N-1:0]  err_set, err_clr, err_flags;
  logic [DW-1:0]     status_w;

  always_comb begin
    wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    wr_lvl  = bus_wr && (bus_addr == A_LEVELS);
    wr_stat = bus_wr && (bus_addr == A_STATUS);
    rd_dat  = bus_rd && (bus_addr == A_DATA);
    flush   = wr_ctrl && bus_wdata[CTRL_FLUSH];
    pop     = rd_dat && !empty && !flush;
    push    = rx_valid && en_q && !flush && (!full || pop);
    err_set[ERR_OVER]  = rx_valid && en_q && !flush && full && !pop;
    err_set[ERR_UNDER] = rd_dat && empty;
    err_clr[ERR_OVER]  = wr_stat && bus_wdata[ST_OVER];
    err_clr[ERR_UNDER] = wr_stat && bus_wdata[ST_UNDER];
  end

  rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (push),
    .pop   (pop),
    .wdata (rx_word),
    .head  (head),
    .count (fill),
    .full  (full),
    .empty (empty)
  );

  rxf_levels #(.DEPTH(DEPTH), .CW(CW), .AEW(AE_W), .AFW(AF_W)) u_levels (
    .count        (fill),
    .ae_level     (lvl_q[AE_LSB +: AE_W]),
    .af_level     (lvl_q[AF_LSB +: AF_W]),
    .almost_empty (aempty),
    .almost_full  (afull)
  );

  rxf_sticky #(.N(ERR_N)) u_errs (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (err_set),
    .clr   (err_clr),
    .flags (err_flags)
  );

  always_comb begin
    status_w             = '0;
    status_w[ST_NEMPTY]  = !empty;
    status_w[ST_NAEMPTY] = !aempty;
    status_w[ST_NAFULL]  = !afull;
    status_w[ST_NFULL]   = !full;
    status_w[ST_UNDER]   = err_flags[ERR_UNDER];
    status_w[ST_OVER]    = err_flags[ERR_OVER];
  end

  always_comb begin
    en_d    = wr_ctrl ? bus_wdata[CTRL_EN] : en_q;
    lvl_d   = wr_lvl ? bus_wdata[LVL_W-1:0] : lvl_q;
    last_d  = pop ? head : last_q;
    rdata_d = rdata_q;
    if (bus_rd) begin
      case (bus_addr)
        A_CTRL:   rdata_d = DW'({en_q, 1'b0});
        A_LEVELS: rdata_d = DW'(lvl_q);
        A_STATUS: rdata_d = status_w;
        A_DATA:   rdata_d = empty ? last_q : head;
        A_FILL:   rdata_d = DW'(CNT_FIELD_W'(fill));
        A_SIZE:   rdata_d = DW'(CNT_FIELD_W'(DEPTH));
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      lvl_q   <= '0;
      rdata_q <= '0;
      last_q  <= '0;
    end else begin
      en_q    <= en_d;
      lvl_q   <= lvl_d;
      rdata_q <= rdata_d;
      last_q  <= last_d;
    end
  end

  assign bus_rdata = rdata_q;

  // R3
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !rd_dat && !flush) |=> $stable(fill));
  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && en_q && full && !rd_dat && !flush) |=> (err_flags[ERR_OVER] && full));
  // R8
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dat && empty) |=> err_flags[ERR_UNDER]);
  // R12
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rx_valid && en_q && rd_dat && !flush && !err_flags[ERR_OVER]) |=> (full && !err_flags[ERR_OVER]));
  // R10
  flush_keeps_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && err_flags[ERR_OVER] && !err_clr[ERR_OVER]) |=> err_flags[ERR_OVER]);
endmodule

// File: tb/tb_rx_port_fifo.sv
`timescale 1ns/1ps
module tb_rx_port_fifo;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [31:0] rx_word = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  rx_port_fifo #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_word(rx_word),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    rx_valid = 1'b1; rx_word = w;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    reg_rd(3'd2, rv); check("R1 status", rv, 32'h0000_C000);
    reg_rd(3'd4, rv); check("R11 fill", rv, 32'd0);
    reg_rd(3'd5, rv); check("R11 size", rv, 32'd16);
  endtask

  task automatic t_enable_order();
    push(32'hDEAD_0001);
    reg_rd(3'd4, rv); check("R3 disabled push ignored", rv, 32'd0);
    reg_wr(3'd0, 32'h2);
    push(32'hA000_0001); push(32'hA000_0002); push(32'hA000_0003);
    reg_rd(3'd4, rv); check("R3 enabled fill", rv, 32'd3);
    for (int i = 1; i <= 3; i++) begin
      reg_rd(3'd3, rv); check("R2 order", rv, 32'hA000_0000 + 32'(i));
    end
  endtask

  task automatic t_levels_full();
    reg_wr(3'd1, 32'h0003_0002);
    push(32'hB000_0001);
    reg_rd(3'd2, rv); check("R4 almost-empty at 1", rv & 32'h0000_2000, 32'h0);
    push(32'hB000_0002); push(32'hB000_0003);
    reg_rd(3'd2, rv); check("R4 not-almost-empty at 3", rv & 32'h0000_3000, 32'h0000_3000);
    for (int i = 4; i <= 12; i++) push(32'hB000_0000 + 32'(i));
    reg_rd(3'd2, rv); check("R5 not-almost-full at 12", rv & 32'h0000_4000, 32'h0000_4000);
    push(32'hB000_000D);
    reg_rd(3'd2, rv); check("R5 almost-full at 13", rv & 32'h0000_4000, 32'h0);
    for (int i = 14; i <= 16; i++) push(32'hB000_0000 + 32'(i));
    reg_rd(3'd2, rv); check("R6 full status", rv, 32'h0000_3000);
    push(32'hBAD0_0BAD);
    reg_rd(3'd4, rv); check("R7 fill stays", rv, 32'd16);
    reg_rd(3'd2, rv); check("R7 overrun", rv & 32'h0080_0000, 32'h0080_0000);
    for (int i = 1; i <= 16; i++) begin
      reg_rd(3'd3, rv); check("R7 drain order", rv, 32'hB000_0000 + 32'(i));
    end
    reg_rd(3'd2, rv); check("R6 empty status", rv & 32'h0000_9000, 32'h0000_8000);
    reg_rd(3'd3, rv); check("R8 underrun data", rv, 32'hB000_0010);
    reg_rd(3'd2, rv); check("R8 underrun flag", rv & 32'h00C0_0000, 32'h00C0_0000);
  endtask

  task automatic t_clear();
    reg_wr(3'd2, 32'h0);
    reg_rd(3'd2, rv); check("R9 zero write keeps", rv & 32'h00C0_0000, 32'h00C0_0000);
    reg_wr(3'd2, 32'h0080_0000);
    reg_rd(3'd2, rv); check("R9 clear overrun only", rv & 32'h00C0_0000, 32'h0040_0000);
    reg_wr(3'd2, 32'h0040_0000);
    reg_rd(3'd2, rv); check("R9 clear underrun", rv & 32'h00C0_0000, 32'h0);
    for (int i = 0; i < DEPTH; i++) push(32'hC000_0000 + 32'(i));
    @(negedge clk);
    rx_valid = 1'b1; rx_word = 32'hEEEE_EEEE;
    bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 32'h0080_0000;
    @(negedge clk);
    rx_valid = 1'b0; bus_wr = 1'b0;
    reg_rd(3'd2, rv); check("R9 set wins over clear", rv & 32'h0080_0000, 32'h0080_0000);
  endtask

  task automatic t_flush();
    reg_wr(3'd0, 32'h3);
    reg_rd(3'd4, rv); check("R10 flush count", rv, 32'd0);
    reg_rd(3'd2, rv); check("R10 flags kept", rv & 32'h0080_0000, 32'h0080_0000);
    @(negedge clk);
    rx_valid = 1'b1; rx_word = 32'h1234_5678;
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h3;
    @(negedge clk);
    rx_valid = 1'b0; bus_wr = 1'b0;
    reg_rd(3'd4, rv); check("R10 flush drops word", rv, 32'd0);
    reg_wr(3'd2, 32'h00C0_0000);
  endtask

  task automatic t_swap();
    for (int i = 0; i < DEPTH; i++) push(32'hD000_0000 + 32'(i));
    @(negedge clk);
    rx_valid = 1'b1; rx_word = 32'hD000_00FF;
    bus_rd = 1'b1; bus_addr = 3'd3;
    @(negedge clk);
    rx_valid = 1'b0; bus_rd = 1'b0;
    check("R12 read head", bus_rdata, 32'hD000_0000);
    reg_rd(3'd4, rv); check("R12 fill", rv, 32'd16);
    reg_rd(3'd2, rv); check("R12 no overrun", rv & 32'h0080_0000, 32'h0);
    for (int i = 1; i < DEPTH; i++) reg_rd(3'd3, rv);
    reg_rd(3'd3, rv); check("R12 pushed word last", rv, 32'hD000_00FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable_order();
    t_levels_full();
    t_clear();
    t_flush();
    t_swap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule